// File: doc/BRIEF.md
# Zero-After-Ones Serial Detector

This block watches a one-bit serial stream, taking one bit on each rising clock edge. It raises its detect output when a 0 comes in right after one or more 1s. The decision is kept in a four-state machine held in two flip-flops. The state advances on every edge, and any 0 returns it to the idle code.

The raw detect output is formed from the present state and the live input bit, in the manner of a Mealy machine. It therefore follows the input between clock edges, and it can pulse briefly when the input wiggles inside a cycle.

For consumers that need a clean signal, a second output holds the value the raw output had at the last rising edge. That registered copy is the only one valid for synchronous logic. An active-low asynchronous reset puts the machine in its idle state and clears the registered output.

Top module: `zero_after_ones_det`

## Requirements
- R1: While `rst_n` is 0, the machine is in the idle state (code 00), `hit_reg` is 0, and `hit_raw` is 0 whatever `bit_in` is. The reset acts at once, without waiting for a clock edge.
- R2: After one or more 0s have been sampled, with no 1 in between, a further 0 on `bit_in` gives `hit_raw` = 0.
- R3: Whenever `bit_in` is 1, `hit_raw` is 0.
- R4: `hit_raw` is 1 exactly when `bit_in` is 0 and the bit sampled at the previous rising edge (since reset) was 1.
- R5: Sampling a 0 returns the machine to the idle state. A 0 that follows a detecting 0 therefore gives `hit_raw` = 0.
- R6: Runs of ones are tracked through the state codes 00 → 01 → 11 → 10, and the machine stays in 10 for longer runs. A 0 that ends a run of length 1, 2, 3 or more asserts `hit_raw`.
- R7: `hit_raw` is combinational. It follows changes of `bit_in` within a cycle, with no clock edge in between.
- R8: `hit_reg` equals the value `hit_raw` had just before the most recent rising edge. Changes of `bit_in` between edges do not reach it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_in | input | 1 | Serial input bit |
| hit_raw | output | 1 | Combinational detect (Mealy) |
| hit_reg | output | 1 | Detect sampled at the last rising edge |

## Verification
Two things can happen in the same cycle: the raw detect output flickers, and the registered output captures a value. The bench provokes this by holding the machine in a non-idle state and toggling `bit_in` 0→1→0→1 between two edges. It checks that `hit_raw` follows each toggle, and that `hit_reg` after the next edge reflects only the value present at that edge. A second collision is tested too: reset is asserted mid-cycle while a detection is pending. The bench checks that both outputs drop at once.

// File: rtl/zad_pkg.sv
package zad_pkg;
    localparam int STATE_W = 2;

    // Codes: bit1 = A, bit0 = B
    typedef enum logic [STATE_W-1:0] {
        ST_IDLE  = 2'b00,  // no pending one
        ST_ONE1  = 2'b01,  // run of exactly one 1
        ST_ONE2  = 2'b11,  // run of exactly two 1s
        ST_ONEN  = 2'b10   // run of three or more 1s
    } zad_state_e;

    typedef struct packed {
        zad_state_e state;
        logic       hit;
    } zad_regs_t;
endpackage

// File: rtl/zad_next_state.sv
module zad_next_state
    import zad_pkg::*;
(
    input  zad_state_e cur,
    input  logic       bit_in,
    output zad_state_e nxt
);
    logic a_bit;
    logic b_bit;
    logic a_nxt;
    logic b_nxt;

    always_comb begin
        a_bit = cur[1];
        b_bit = cur[0];
        a_nxt = (a_bit | b_bit) & bit_in;
        b_nxt = ~a_bit & bit_in;
        nxt   = zad_state_e'({a_nxt, b_nxt});
    end
endmodule

// File: rtl/zad_mealy_out.sv
module zad_mealy_out
    import zad_pkg::*;
(
    input  zad_state_e cur,
    input  logic       bit_in,
    output logic       hit
);
    always_comb begin
        hit = (cur != ST_IDLE) & ~bit_in;
    end
endmodule

// File: rtl/zero_after_ones_det.sv
module zero_after_ones_det
    import zad_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic bit_in,
    output logic hit_raw,
    output logic hit_reg
);
    zad_regs_t  regs_d;
    zad_regs_t  regs_q;
    zad_state_e state_q;
    zad_state_e state_nxt;
    logic       hit_now;

    assign state_q = regs_q.state;

    zad_next_state i_next (
        .cur    (state_q),
        .bit_in (bit_in),
        .nxt    (state_nxt)
    );

    zad_mealy_out i_out (
        .cur    (state_q),
        .bit_in (bit_in),
        .hit    (hit_now)
    );

    always_comb begin
        regs_d       = regs_q;
        regs_d.state = state_nxt;
        regs_d.hit   = hit_now;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q.state <= ST_IDLE;
            regs_q.hit   <= 1'b0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign hit_raw = hit_now;
    assign hit_reg = regs_q.hit;
endmodule

// File: rtl/zad_checker.sv
module zad_checker
    import zad_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       bit_in,
    input logic       hit_raw,
    input logic       hit_reg,
    input zad_state_e state_q
);
    logic last_one;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) last_one <= 1'b0;
        else        last_one <= bit_in;
    end

    a_r1_reset_idle: assert property (@(posedge clk)
        !rst_n |-> (state_q == ST_IDLE && !hit_reg && !hit_raw));

    a_r3_ones_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        bit_in |-> !hit_raw);

    a_r4_fire_rule: assert property (@(posedge clk) disable iff (!rst_n)
        hit_raw == (last_one && !bit_in));

    a_r5_zero_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_in |=> state_q == ST_IDLE);

    a_r6_one_leaves_idle: assert property (@(posedge clk) disable iff (!rst_n)
        bit_in |=> state_q != ST_IDLE);

    a_r6_long_run_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ONEN && bit_in) |=> state_q == ST_ONEN);

    a_r8_reg_follows: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> hit_reg == $past(hit_raw));
endmodule

bind zero_after_ones_det zad_checker i_zad_checker (
    .clk     (clk),
    .rst_n   (rst_n),
    .bit_in  (bit_in),
    .hit_raw (hit_raw),
    .hit_reg (hit_reg),
    .state_q (state_q)
);

// File: tb/test_zero_after_ones_det.sv
`timescale 1ns/1ps
module test_zero_after_ones_det;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bit_in = 1'b0;
    logic hit_raw;
    logic hit_reg;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;
    bit prev_one = 1'b0;

    always #10 clk = ~clk;

    zero_after_ones_det i_zero_after_ones_det (
        .clk     (clk),
        .rst_n   (rst_n),
        .bit_in  (bit_in),
        .hit_raw (hit_raw),
        .hit_reg (hit_reg)
    );

    task automatic chk(input bit ok, input string req, input logic act, input logic exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
        end
    endtask

    // Called 1ns after a rising edge; consumes one cycle.
    task automatic apply_bit(input logic b, input string req);
        logic exp;
        bit_in = b;
        exp = prev_one && !b;
        #8;
        chk(hit_raw === exp, req, hit_raw, exp);
        @(posedge clk); #1;
        chk(hit_reg === exp, {req, "/R8"}, hit_reg, exp);
        prev_one = b;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        bit_in = 1'b1;
        @(posedge clk); #1;
        chk(hit_raw === 1'b0, "R1 raw in reset", hit_raw, 1'b0);
        chk(hit_reg === 1'b0, "R1 reg in reset", hit_reg, 1'b0);
        bit_in = 1'b0;
        #2;
        chk(hit_raw === 1'b0, "R1 raw in reset x=0", hit_raw, 1'b0);
        @(posedge clk); #1;
        rst_n = 1'b1;
        prev_one = 1'b0;
    endtask

    task automatic t_zeros();
        for (int i = 0; i < 4; i++) apply_bit(1'b0, "R2 zeros stay quiet");
    endtask

    task automatic t_ones();
        for (int i = 0; i < 5; i++) apply_bit(1'b1, "R3 ones keep raw low");
    endtask

    task automatic t_runs();
        for (int len = 1; len <= 5; len++) begin
            for (int i = 0; i < len; i++) apply_bit(1'b1, "R6 run of ones");
            apply_bit(1'b0, "R4 R6 zero after run fires");
            apply_bit(1'b0, "R5 second zero quiet");
        end
        apply_bit(1'b1, "R3 alternate");
        apply_bit(1'b0, "R4 alternate fire");
        apply_bit(1'b1, "R3 alternate");
        apply_bit(1'b0, "R4 alternate fire");
    endtask

    task automatic t_glitch();
        apply_bit(1'b1, "R3 prime");
        bit_in = 1'b0; #2;
        chk(hit_raw === 1'b1, "R7 raw follows 0", hit_raw, 1'b1);
        bit_in = 1'b1; #2;
        chk(hit_raw === 1'b0, "R7 raw follows 1", hit_raw, 1'b0);
        bit_in = 1'b0; #2;
        chk(hit_raw === 1'b1, "R7 raw follows 0 again", hit_raw, 1'b1);
        bit_in = 1'b1; #2;
        @(posedge clk); #1;
        chk(hit_reg === 1'b0, "R8 glitch not captured", hit_reg, 1'b0);
        prev_one = 1'b1;
        apply_bit(1'b0, "R4 fire after glitch cycle");
    endtask

    task automatic t_mid_reset();
        apply_bit(1'b1, "R3 before reset");
        bit_in = 1'b0; #3;
        chk(hit_raw === 1'b1, "R4 pending hit", hit_raw, 1'b1);
        rst_n = 1'b0; #1;
        chk(hit_raw === 1'b0, "R1 async reset clears raw", hit_raw, 1'b0);
        @(posedge clk); #1;
        chk(hit_reg === 1'b0, "R1 reg cleared", hit_reg, 1'b0);
        rst_n = 1'b1;
        prev_one = 1'b0;
        apply_bit(1'b0, "R2 quiet after reset");
        apply_bit(1'b1, "R3 after reset");
        apply_bit(1'b0, "R4 fire after reset");
    endtask

    initial begin
        #200000;
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_zeros();
        t_ones();
        t_runs();
        t_glitch();
        t_mid_reset();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule